// File: doc/BRIEF.md
# MIDI Host Port with UART-Mode Command Set

This block sits between a byte-wide host bus and a serial MIDI link. It looks to software like a classic dumb-UART MIDI adapter. It decodes two host addresses. Address 0 is the data register: reads return the held receive byte and writes send a byte. Address 1 is the command register on writes and the status register on reads. Two status flags tell software when it may read and when it may write. Both flags are active-low ready indicators.

The serial framing lives in a separate serializer/deserializer and is not part of this block. The block hands one transmit byte at a time to that serializer through a valid/ready pair. It accepts one received byte per `rx_valid` pulse. It holds a single byte in each direction. Only two command codes are recognised:
- The reset code returns the port to its idle, non-UART mode.
- The UART code turns on byte pass-through.

Both recognised commands place an acknowledge byte in the receive register. Level interrupt requests signal "transmit register empty" and "receive byte waiting". Each request is gated by its own enable input.

Top module: `midi_host_port`

## Requirements
- R1: After reset the status register (address 1) reads 0x80: bit 7 = 1 (nothing to read), bit 6 = 0 (ready to accept), bits 5..0 = 0. `tx_valid`, `overrun` and both interrupt requests are low (with enables low), and the port is not in UART mode.
- R2: The status register shows bit 7 = 0 exactly while the receive register holds an unread byte, and bit 6 = 1 exactly while the transmit register holds a byte not yet taken by the serializer. Bits 5..0 always read 0.
- R3: Writing 0x3F to address 1 while bit 6 = 0 enters UART mode, loads the acknowledge byte 0xFE into the receive register and clears status bit 7.
- R4: Writing 0xFF to address 1 while bit 6 = 0 leaves UART mode, clears the overrun flag, loads 0xFE into the receive register and clears status bit 7.
- R5: Any other byte written to address 1 is ignored: no acknowledge is produced and the mode is unchanged.
- R6: Reading address 0 returns the held receive byte and sets status bit 7 back to 1. Reading it again with nothing new returns the same byte and leaves status unchanged.
- R7: In UART mode, writing address 0 while bit 6 = 0 loads the transmit register. `tx_valid` then stays high and `tx_byte` stays stable until a cycle with `tx_ready` high. Any write, data or command, made while bit 6 = 1 is dropped.
- R8: Outside UART mode, data writes to address 0 are dropped and received serial bytes are discarded.
- R9: In UART mode an `rx_valid` pulse loads `rx_byte` into the receive register and clears status bit 7.
- R10: A byte received while the previous byte is unread overwrites it and sets the sticky `overrun` output, which stays set until a reset command. If a data read and an arrival fall in the same cycle, the read returns the old byte, the new byte is held, and no overrun is flagged.
- R11: `irq_tx` is high when `tx_irq_en` is high and status bit 6 is 0. `irq_rx` is high when `rx_irq_en` is high and status bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = command/status register |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data, valid during a read strobe, 0 otherwise |
| tx_valid | output | 1 | Transmit register holds a byte for the serializer |
| tx_byte | output | DATA_W | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte this cycle |
| rx_valid | input | 1 | Deserializer delivers a byte this cycle |
| rx_byte | input | DATA_W | Received byte |
| tx_irq_en | input | 1 | Enable for the transmit-empty request |
| rx_irq_en | input | 1 | Enable for the receive request |
| irq_tx | output | 1 | Transmit register empty request |
| irq_rx | output | 1 | Receive byte waiting request |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, reset code 0xFF, UART code 0x3F and acknowledge 0xFE. These values match the encodings the requirements name, so every expected status byte and acknowledge is a literal the bench compares against. With the serializer's ready held low, the bench can keep the transmit register occupied for as long as it wants. That reaches the dropped-write and dropped-command paths. Because received bytes are delivered on cycles the bench picks, the overwrite, the same-cycle read-and-arrival case, and the discard outside UART mode can all be placed exactly.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;

    localparam int MIDI_BYTE_W = 8;

    // Host register select, driven by the single address bit
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Outcome of a command write
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_RST   = 2'd1,
        CMD_ENTER = 2'd2
    } cmd_kind_e;

    // Data-register side effects of one bus access
    typedef struct packed {
        logic tx_load;
        logic rx_take;
    } bus_req_t;

    // Active-low ready flags: {input ready_n, output ready_n}
    function automatic logic [1:0] status_flags(input logic rx_full, input logic tx_full);
        return {~rx_full, tx_full};
    endfunction

endpackage

// File: rtl/midi_bus_decode.sv
module midi_bus_decode
    import midi_port_pkg::*;
#(
    parameter int                DATA_W    = MIDI_BYTE_W,
    parameter logic [DATA_W-1:0] CMD_RESET = 8'hFF,
    parameter logic [DATA_W-1:0] CMD_UART  = 8'h3F
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tx_busy,
    input  logic              uart_mode,
    output bus_req_t          req,
    output cmd_kind_e         cmd
);

    function automatic cmd_kind_e classify(input logic [DATA_W-1:0] code);
        if (code == CMD_RESET)     return CMD_RST;
        else if (code == CMD_UART) return CMD_ENTER;
        else                       return CMD_NONE;
    endfunction

    reg_sel_e target;
    assign target = reg_sel_e'(bus_addr);

    always_comb begin
        req = '0;
        cmd = CMD_NONE;
        if (bus_sel) begin
            if (bus_wr) begin
                // writes of either kind are refused while the output side is occupied
                if (!tx_busy) begin
                    if (target == SEL_CTRL)
                        cmd = classify(bus_wdata);
                    else if (uart_mode)
                        req.tx_load = 1'b1;
                end
            end else if (target == SEL_DATA) begin
                req.rx_take = 1'b1;
            end
        end
    end

endmodule

// File: rtl/midi_tx_hold.sv
module midi_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (full && take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/midi_rx_hold.sv
module midi_rx_hold #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] ACK_CODE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_load,
    input  logic              ovr_clear,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] hold,
    output logic              ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            hold <= '0;
        end else if (ack_load) begin
            full <= 1'b1;
            hold <= ACK_CODE;
        end else if (in_valid) begin
            full <= 1'b1;
            hold <= in_byte;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovr <= 1'b0;
        else if (ovr_clear)
            ovr <= 1'b0;
        else if (!ack_load && in_valid && full && !take)
            ovr <= 1'b1;
    end

endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
    import midi_port_pkg::*;
#(
    parameter int                DATA_W    = MIDI_BYTE_W,
    parameter logic [DATA_W-1:0] CMD_RESET = 8'hFF,
    parameter logic [DATA_W-1:0] CMD_UART  = 8'h3F,
    parameter logic [DATA_W-1:0] ACK_CODE  = 8'hFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              overrun
);

    localparam int FLAG_HI = DATA_W - 1;

    logic              uart_mode;
    logic              rx_full;
    logic [DATA_W-1:0] rx_hold;
    logic [DATA_W-1:0] status_word;
    bus_req_t          req;
    cmd_kind_e         cmd;

    midi_bus_decode #(
        .DATA_W(DATA_W), .CMD_RESET(CMD_RESET), .CMD_UART(CMD_UART)
    ) u_decode (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tx_busy(tx_valid), .uart_mode(uart_mode),
        .req(req), .cmd(cmd)
    );

    midi_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .load(req.tx_load), .din(bus_wdata),
        .take(tx_ready), .full(tx_valid), .dout(tx_byte)
    );

    midi_rx_hold #(.DATA_W(DATA_W), .ACK_CODE(ACK_CODE)) u_rx (
        .clk(clk), .rst(rst),
        .ack_load(cmd != CMD_NONE), .ovr_clear(cmd == CMD_RST),
        .in_valid(rx_valid && uart_mode), .in_byte(rx_byte),
        .take(req.rx_take), .full(rx_full), .hold(rx_hold), .ovr(overrun)
    );

    always_ff @(posedge clk) begin
        if (rst)
            uart_mode <= 1'b0;
        else if (cmd == CMD_ENTER)
            uart_mode <= 1'b1;
        else if (cmd == CMD_RST)
            uart_mode <= 1'b0;
    end

    always_comb begin
        status_word = '0;
        status_word[FLAG_HI -: 2] = status_flags(rx_full, tx_valid);
    end

    always_comb begin
        if (bus_sel && !bus_wr)
            bus_rdata = (reg_sel_e'(bus_addr) == SEL_CTRL) ? status_word : rx_hold;
        else
            bus_rdata = '0;
    end

    assign irq_tx = tx_irq_en && !tx_valid;
    assign irq_rx = rx_irq_en && rx_full;

endmodule

// File: rtl/midi_host_port_chk.sv
module midi_host_port_chk #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] CMD_RESET = 8'hFF,
    parameter logic [DATA_W-1:0] CMD_UART  = 8'h3F
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_byte,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_irq_en,
    input logic              irq_rx,
    input logic              overrun,
    input logic              rx_full,
    input logic              uart_mode
);

    logic ctrl_wr;
    assign ctrl_wr = bus_sel && bus_wr && bus_addr;

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R3
    uart_enter_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && bus_wdata == CMD_UART && !tx_valid |=> uart_mode && rx_full);

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun && !(ctrl_wr && bus_wdata == CMD_RESET) |=> overrun);

    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_valid && rx_full));

    // R8
    idle_discard_chk: assert property (@(posedge clk) disable iff (rst)
        !uart_mode && rx_valid && !rx_full && !ctrl_wr |=> !rx_full);

    // R11
    irq_rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> rx_irq_en && rx_full);

endmodule

bind midi_host_port midi_host_port_chk #(
    .DATA_W(DATA_W), .CMD_RESET(CMD_RESET), .CMD_UART(CMD_UART)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_irq_en(rx_irq_en), .irq_rx(irq_rx), .overrun(overrun),
    .rx_full(rx_full), .uart_mode(uart_mode)
);

// File: tb/test_midi_host_port.sv
module test_midi_host_port;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         tx_valid;
    logic [W-1:0] tx_byte;
    logic         tx_ready = 1'b0;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_byte = '0;
    logic         tx_irq_en = 1'b0, rx_irq_en = 1'b0;
    logic         irq_tx, irq_rx, overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    midi_host_port i_midi_host_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_irq_en(tx_irq_en),
        .rx_irq_en(rx_irq_en), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic addr, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_push(input logic [W-1:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] s;
        bus_read(1'b1, s);
        check("R1 status", s, 8'h80);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 overrun", overrun, 0);
        check("R1 irq_tx", irq_tx, 0);
        check("R1 irq_rx", irq_rx, 0);
    endtask

    task automatic t_idle_mode();
        logic [W-1:0] s;
        bus_write(1'b0, 8'h55);
        check("R8 data write dropped", tx_valid, 0);
        rx_push(8'h12);
        bus_read(1'b1, s);
        check("R8 rx byte discarded", s, 8'h80);
        bus_write(1'b1, 8'h20);
        bus_read(1'b1, s);
        check("R5 unknown command no ack", s, 8'h80);
        bus_write(1'b0, 8'h66);
        check("R5 mode unchanged", tx_valid, 0);
    endtask

    task automatic t_enter_uart();
        logic [W-1:0] s, d;
        bus_write(1'b1, 8'h3F);
        bus_read(1'b1, s);
        check("R3 status after enter", s, 8'h00);
        bus_read(1'b0, d);
        check("R3 ack byte", d, 8'hFE);
        bus_read(1'b1, s);
        check("R6 status after read", s, 8'h80);
        bus_read(1'b0, d);
        check("R6 repeat read", d, 8'hFE);
        bus_read(1'b1, s);
        check("R6 status unchanged", s, 8'h80);
    endtask

    task automatic t_transmit();
        logic [W-1:0] s;
        tx_irq_en = 1'b1;
        #1 check("R11 irq_tx when empty", irq_tx, 1);
        bus_write(1'b0, 8'h90);
        check("R7 tx_valid", tx_valid, 1);
        check("R7 tx_byte", tx_byte, 8'h90);
        check("R11 irq_tx when busy", irq_tx, 0);
        bus_read(1'b1, s);
        check("R2 status busy", s, 8'hC0);
        bus_write(1'b0, 8'h11);
        check("R7 write while busy dropped", tx_byte, 8'h90);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, s);
        check("R7 command while busy dropped", s, 8'hC0);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R7 taken", tx_valid, 0);
        check("R11 irq_tx after take", irq_tx, 1);
        bus_read(1'b1, s);
        check("R2 status idle", s, 8'h80);
    endtask

    task automatic t_receive();
        logic [W-1:0] s, d;
        rx_irq_en = 1'b1;
        rx_push(8'h3C);
        bus_read(1'b1, s);
        check("R9 status after arrival", s, 8'h00);
        check("R11 irq_rx", irq_rx, 1);
        bus_read(1'b0, d);
        check("R9 byte", d, 8'h3C);
        check("R11 irq_rx cleared", irq_rx, 0);
        check("R10 no overrun yet", overrun, 0);
        rx_push(8'h41);
        rx_push(8'h42);
        check("R10 overrun set", overrun, 1);
        bus_read(1'b0, d);
        check("R10 newest byte kept", d, 8'h42);
        check("R10 overrun sticky", overrun, 1);
    endtask

    task automatic t_reset_cmd();
        logic [W-1:0] s, d;
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, s);
        check("R4 status after reset cmd", s, 8'h00);
        check("R4 overrun cleared", overrun, 0);
        bus_read(1'b0, d);
        check("R4 ack byte", d, 8'hFE);
        rx_push(8'h77);
        bus_read(1'b1, s);
        check("R4 left uart mode", s, 8'h80);
    endtask

    task automatic t_same_cycle();
        logic [W-1:0] s, d;
        bus_write(1'b1, 8'h3F);
        bus_read(1'b0, d);
        rx_push(8'h50);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
        rx_valid = 1'b1; rx_byte = 8'h51;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        check("R10 read old byte", d, 8'h50);
        check("R10 no overrun on same cycle", overrun, 0);
        bus_read(1'b1, s);
        check("R10 new byte held", s, 8'h00);
        bus_read(1'b0, d);
        check("R10 new byte value", d, 8'h51);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle_mode();
        t_enter_uart();
        t_transmit();
        t_receive();
        t_reset_cmd();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule